// File: doc/BRIEF.md
# NAND Page-Read Boot Copier

This block is a hardware sequencer that moves a region of a parallel NAND flash into on-chip RAM without processor help. A single start pulse latches a source byte offset, a destination word address, a byte count and a bus-width mode. The block then works page by page. For each page it drives chip enable, the command latch, the address latch and the write strobe to send a read command and a full address. It waits for the flash ready/busy line, clocks the page out with the read strobe, and writes every word to a plain RAM write port.

A fresh command and address go out for every page, so the flash's internal address counter never runs on into the spare area. In 16-bit mode the byte offset is halved into a word offset and full 16-bit words are stored. In 8-bit mode the offset is used unchanged and each byte is stored zero-extended. A one-cycle done pulse marks the end of the copy.

Top module: `nand_boot_copier`

## Requirements
- R1: While reset is held, and after it until a start is accepted, chip enable, the read strobe and the write strobe are high (inactive), command latch and address latch are low, and the RAM write enable and done are low.
- R2: Each page begins with the command latch high and chip enable low, and exactly one write strobe carries the read command 0x00 on bits [7:0]. Command latch and address latch are never high together, and the write strobe only falls while chip enable is low.
- R3: After the command, three write strobes go out with the address latch high. They carry 0x00 (column), then bits [15:8] of the current page offset, then bits [23:16].
- R4: The command latch and the address latch each stay high for at least SETTLE_CYC (default 20) clock cycles after their last write strobe returns high.
- R5: No read strobe falls until the ready/busy input has gone high after the address phase. The flash must drive it low before the settle delay ends.
- R6: With x16_i high at start, the offset used is src_off_i shifted right by one. A page is 256 words and each RAM word is the full 16-bit flash word.
- R7: With x16_i low at start, the offset used is src_off_i unchanged. A page is 512 words and each RAM word is {8'h00, flash bits [7:0]}.
- R8: After each page the offset grows by the page length in words, and the next page again sends a full command and address.
- R9: The number of pages copied is byte_cnt_i / 512 + 1: after each page 512 is taken off the remaining count, and copying goes on while the result is not negative.
- R10: Every flash word produces one single-cycle RAM write. Addresses start at dst_addr_i and rise by one per word, in flash read order.
- R11: The read strobe stays low for at least two cycles per word and never overlaps a write strobe. Data is taken in the last low cycle.
- R12: When the last page ends, chip enable returns high and done pulses for exactly one cycle.
- R13: A start pulse that arrives while a copy is running has no effect on that copy.
- R14: A start pulse that arrives in the same cycle as done is accepted and begins a new copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| x16_i | input | 1 | 1 = 16-bit flash, 0 = 8-bit flash |
| src_off_i | input | 24 | Source byte offset in flash |
| dst_addr_i | input | AW | First RAM word address |
| byte_cnt_i | input | CNT_W | Byte count for the copy loop |
| done_o | output | 1 | One-cycle completion pulse |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Command and address data to flash |
| nand_dq_oe_o | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 16 | Data from flash |
| nand_rb_i | input | 1 | Ready (1) / busy (0) from flash |
| ram_we_o | output | 1 | RAM write enable pulse |
| ram_addr_o | output | AW | RAM word address |
| ram_wdata_o | output | 16 | RAM write data |

## Verification
Two functions can fall in the same cycle: the done pulse that closes one copy and the acceptance of the next start pulse. The bench provokes this by raising start in the very cycle done is seen, with new offset, destination and mode. The scoreboard must then receive the second copy's full command, address and RAM write stream, and no stale or missing words may appear between the two copies. In a separate run, a start pulse is injected mid-copy, and the unchanged expectation queues show that it was ignored.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int ROW_W = 24;
  localparam logic [7:0] CMD_PAGE_READ = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_CMD_SETTLE,
    ST_ADDR,
    ST_ADDR_SETTLE,
    ST_WAIT_RDY,
    ST_READ,
    ST_PAGE_END
  } nbc_state_e;
endpackage

// File: rtl/nbc_sync.sv
module nbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nbc_settle.sv
module nbc_settle #(
  parameter int LIMIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/nbc_cursor.sv
module nbc_cursor
  import nbc_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CNT_W      = 24,
  parameter int PAGE_BYTES = 512,
  localparam int WI_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             x16_i,
  input  logic [ROW_W-1:0] off_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             word_adv_i,
  input  logic             page_adv_i,
  output logic [7:0]       row_lo_o,
  output logic [7:0]       row_hi_o,
  output logic [AW-1:0]    dst_o,
  output logic             x16_o,
  output logic             last_page_o,
  output logic [WI_W-1:0]  last_word_o
);
  localparam int PW8  = PAGE_BYTES;
  localparam int PW16 = PAGE_BYTES / 2;

  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] remain_q;
  logic [AW-1:0]    dst_q;
  logic             x16_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q    <= '0;
      remain_q <= '0;
      dst_q    <= '0;
      x16_q    <= 1'b0;
    end else if (load_i) begin
      row_q    <= x16_i ? {1'b0, off_i[ROW_W-1:1]} : off_i;
      remain_q <= cnt_i;
      dst_q    <= dst_i;
      x16_q    <= x16_i;
    end else begin
      if (word_adv_i) dst_q <= dst_q + 1'b1;
      if (page_adv_i) begin
        row_q    <= row_q + (x16_q ? ROW_W'(PW16) : ROW_W'(PW8));
        remain_q <= remain_q - CNT_W'(PAGE_BYTES);
      end
    end
  end

  assign row_lo_o    = row_q[15:8];
  assign row_hi_o    = row_q[23:16];
  assign dst_o       = dst_q;
  assign x16_o       = x16_q;
  assign last_page_o = remain_q < CNT_W'(PAGE_BYTES);
  assign last_word_o = x16_q ? WI_W'(PW16 - 1) : WI_W'(PW8 - 1);
endmodule

// File: rtl/nand_boot_copier.sv
module nand_boot_copier
  import nbc_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CNT_W      = 24,
  parameter int PAGE_BYTES = 512,
  parameter int SETTLE_CYC = 20,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             x16_i,
  input  logic [23:0]      src_off_i,
  input  logic [AW-1:0]    dst_addr_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  output logic             done_o,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [15:0]      nand_dq_o,
  output logic             nand_dq_oe_o,
  input  logic [15:0]      nand_dq_i,
  input  logic             nand_rb_i,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [15:0]      ram_wdata_o
);
  localparam int WI_W = $clog2(PAGE_BYTES);

  nbc_state_e     state_q;
  logic [1:0]     ph_q;
  logic [1:0]     aidx_q;
  logic [WI_W-1:0] widx_q;

  logic           rb_sync;
  logic           settle_run, settle_done;
  logic           load, word_adv, page_adv;
  logic [7:0]     row_lo, row_hi;
  logic [AW-1:0]  dst;
  logic           x16_act, last_page;
  logic [WI_W-1:0] last_word;

  assign settle_run = (state_q == ST_CMD_SETTLE) || (state_q == ST_ADDR_SETTLE);
  assign load       = (state_q == ST_IDLE) && start_i;
  assign word_adv   = (state_q == ST_READ) && (ph_q == 2'd2);
  assign page_adv   = (state_q == ST_PAGE_END);

  nbc_sync #(.STAGES(SYNC_STG)) u_rb_sync (
    .clk_i, .rst_ni, .async_i(nand_rb_i), .sync_o(rb_sync)
  );

  nbc_settle #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni, .run_i(settle_run), .expire_o(settle_done)
  );

  nbc_cursor #(.AW(AW), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_cursor (
    .clk_i, .rst_ni,
    .load_i(load), .x16_i, .off_i(src_off_i), .dst_i(dst_addr_i), .cnt_i(byte_cnt_i),
    .word_adv_i(word_adv), .page_adv_i(page_adv),
    .row_lo_o(row_lo), .row_hi_o(row_hi), .dst_o(dst), .x16_o(x16_act),
    .last_page_o(last_page), .last_word_o(last_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ph_q         <= '0;
      aidx_q       <= '0;
      widx_q       <= '0;
      nand_ce_no   <= 1'b1;
      nand_cle_o   <= 1'b0;
      nand_ale_o   <= 1'b0;
      nand_we_no   <= 1'b1;
      nand_re_no   <= 1'b1;
      nand_dq_o    <= '0;
      nand_dq_oe_o <= 1'b0;
      ram_we_o     <= 1'b0;
      ram_addr_o   <= '0;
      ram_wdata_o  <= '0;
      done_o       <= 1'b0;
    end else begin
      ram_we_o <= 1'b0;
      done_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            nand_ce_no   <= 1'b0;
            nand_cle_o   <= 1'b1;
            nand_dq_o    <= {8'h00, CMD_PAGE_READ};
            nand_dq_oe_o <= 1'b1;
            ph_q         <= '0;
            state_q      <= ST_CMD;
          end
        end
        // write strobe: low in phases 1..2, high in phase 3
        ST_CMD: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == 2'd0) nand_we_no <= 1'b0;
          if (ph_q == 2'd2) nand_we_no <= 1'b1;
          if (ph_q == 2'd3) state_q <= ST_CMD_SETTLE;
        end
        ST_CMD_SETTLE: begin
          if (settle_done) begin
            nand_cle_o <= 1'b0;
            nand_ale_o <= 1'b1;
            nand_dq_o  <= '0;
            aidx_q     <= '0;
            ph_q       <= '0;
            state_q    <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == 2'd0) nand_we_no <= 1'b0;
          if (ph_q == 2'd2) nand_we_no <= 1'b1;
          if (ph_q == 2'd3) begin
            if (aidx_q == 2'd2) begin
              state_q <= ST_ADDR_SETTLE;
            end else begin
              aidx_q    <= aidx_q + 1'b1;
              nand_dq_o <= {8'h00, (aidx_q == 2'd0) ? row_lo : row_hi};
            end
          end
        end
        ST_ADDR_SETTLE: begin
          if (settle_done) begin
            nand_ale_o   <= 1'b0;
            nand_dq_oe_o <= 1'b0;
            state_q      <= ST_WAIT_RDY;
          end
        end
        ST_WAIT_RDY: begin
          if (rb_sync) begin
            widx_q  <= '0;
            ph_q    <= '0;
            state_q <= ST_READ;
          end
        end
        // read strobe low in phases 1..2, sample at end of phase 2
        ST_READ: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == 2'd0) nand_re_no <= 1'b0;
          if (ph_q == 2'd2) begin
            nand_re_no  <= 1'b1;
            ram_we_o    <= 1'b1;
            ram_addr_o  <= dst;
            ram_wdata_o <= x16_act ? nand_dq_i : {8'h00, nand_dq_i[7:0]};
          end
          if (ph_q == 2'd3) begin
            if (widx_q == last_word) state_q <= ST_PAGE_END;
            else widx_q <= widx_q + 1'b1;
          end
        end
        ST_PAGE_END: begin
          if (last_page) begin
            nand_ce_no <= 1'b1;
            done_o     <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            nand_cle_o   <= 1'b1;
            nand_dq_o    <= {8'h00, CMD_PAGE_READ};
            nand_dq_oe_o <= 1'b1;
            ph_q         <= '0;
            state_q      <= ST_CMD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbc_checker.sv
module nbc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic nand_ce_no,
  input logic nand_cle_o,
  input logic nand_ale_o,
  input logic nand_we_no,
  input logic nand_re_no,
  input logic nand_rb_i,
  input logic ram_we_o,
  input logic done_o
);
  p_latch_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  p_we_under_ce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> !nand_ce_no);

  p_ready_before_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_re_no) |-> nand_rb_i);

  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  p_re_two_cycles_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_re_no) |=> !nand_re_no);

  p_ram_we_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);

  p_done_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ce_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> nand_ce_no);
endmodule

bind nand_boot_copier nbc_checker u_nbc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nand_ce_no (nand_ce_no),
  .nand_cle_o (nand_cle_o),
  .nand_ale_o (nand_ale_o),
  .nand_we_no (nand_we_no),
  .nand_re_no (nand_re_no),
  .nand_rb_i  (nand_rb_i),
  .ram_we_o   (ram_we_o),
  .done_o     (done_o)
);

// File: tb/sim_nand_boot_copier.sv
`timescale 1ns/1ps
module sim_nand_boot_copier;
  localparam int AW     = 16;
  localparam int CNT_W  = 24;
  localparam int SETTLE = 20;
  localparam int BUSY   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             start = 1'b0;
  logic             x16 = 1'b0;
  logic [23:0]      src_off = '0;
  logic [AW-1:0]    dst_addr = '0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic             done;
  logic             ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [15:0]      dq_o;
  logic [15:0]      dq_i = '0;
  logic             rb = 1'b1;
  logic             ram_we;
  logic [AW-1:0]    ram_addr;
  logic [15:0]      ram_wdata;

  nand_boot_copier #(.AW(AW), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .x16_i(x16),
    .src_off_i(src_off), .dst_addr_i(dst_addr), .byte_cnt_i(byte_cnt),
    .done_o(done), .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe),
    .nand_dq_i(dq_i), .nand_rb_i(rb),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata)
  );

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  string cur_tag = "R10";
  logic [31:0] exp_ram_q[$];
  logic [9:0]  exp_bus_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fdata(input logic [23:0] row, input int w);
    logic [15:0] a;
    a = row[23:8] ^ 16'h9100;
    return (a * 16'd13) + (16'(w) * 16'h0107) + 16'h3c5a;
  endfunction

  // flash model and bus scoreboard
  int cyc = 0, last_we_cyc = 0, re_low = 0, busy_left = 0, aidx = 0, widx = 0;
  logic [7:0]  abyte [3];
  logic [23:0] mrow = '0;
  logic p_we = 1'b1, p_re = 1'b1, p_cle = 1'b0, p_ale = 1'b0, p_done = 1'b0;

  always @(negedge clk) begin
    logic [9:0] act, e;
    cyc++;
    if (rst_n) begin
      if (!rb) begin
        if (busy_left == 0) rb = 1'b1;
        else busy_left--;
      end
      if (we_n && !p_we) begin
        act = {cle, ale, dq_o[7:0]};
        last_we_cyc = cyc;
        if (exp_bus_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected bus write", 32'(act), 32'h0);
        end else begin
          e = exp_bus_q.pop_front();
          chk(act == e, e[9] ? "R2" : "R3", "bus write", 32'(act), 32'(e));
        end
        if (cle) aidx = 0;
        if (ale) begin
          abyte[aidx] = dq_o[7:0];
          aidx++;
          if (aidx == 3) begin
            mrow = {abyte[2], abyte[1], 8'h00};
            widx = 0;
            aidx = 0;
            rb = 1'b0;
            busy_left = BUSY;
          end
        end
      end
      if (!cle && p_cle)
        chk((cyc - last_we_cyc >= SETTLE) && (cyc - last_we_cyc <= SETTLE + 3),
            "R4", "command latch hold", 32'(cyc - last_we_cyc), 32'(SETTLE));
      if (!ale && p_ale)
        chk((cyc - last_we_cyc >= SETTLE) && (cyc - last_we_cyc <= SETTLE + 3),
            "R4", "address latch hold", 32'(cyc - last_we_cyc), 32'(SETTLE));
      if (!re_n && p_re) begin
        if (!rb) chk(1'b0, "R5", "read strobe while busy", 32'(rb), 32'h1);
        dq_i = fdata(mrow, widx);
        widx++;
        re_low = 0;
      end
      if (!re_n) re_low++;
      if (re_n && !p_re) chk(re_low >= 2, "R11", "read strobe low cycles", 32'(re_low), 32'h2);
      if (ram_we) begin
        if (exp_ram_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected RAM write", {ram_addr, ram_wdata}, 32'h0);
        end else begin
          logic [31:0] er;
          er = exp_ram_q.pop_front();
          chk({ram_addr, ram_wdata} == er, cur_tag, "RAM write {addr,data}",
              {ram_addr, ram_wdata}, er);
        end
      end
      if (done) begin
        done_cnt++;
        chk(ce_n == 1'b1, "R12", "chip enable at done", 32'(ce_n), 32'h1);
      end
      if (p_done) chk(!done, "R12", "done width", 32'(done), 32'h0);
    end
    p_we = we_n; p_re = re_n; p_cle = cle; p_ale = ale; p_done = done;
  end

  // driver: pushes expectations, then pulses start
  task automatic run_copy(input logic m16, input logic [23:0] off, input logic [AW-1:0] dst,
                          input logic [CNT_W-1:0] cnt, input string tag, input bit b2b);
    int pw, pages;
    logic [23:0] base, row;
    logic [15:0] d;
    logic [AW-1:0] a;
    pw    = m16 ? 256 : 512;
    base  = m16 ? (off >> 1) : off;
    pages = int'(cnt / 512) + 1;
    a     = dst;
    cur_tag = tag;
    for (int p = 0; p < pages; p++) begin
      row = base + 24'(p * pw);
      exp_bus_q.push_back({2'b10, 8'h00});
      exp_bus_q.push_back({2'b01, 8'h00});
      exp_bus_q.push_back({2'b01, row[15:8]});
      exp_bus_q.push_back({2'b01, row[23:16]});
      for (int w = 0; w < pw; w++) begin
        d = fdata({row[23:8], 8'h00}, w);
        exp_ram_q.push_back({a, m16 ? d : {8'h00, d[7:0]}});
        a++;
      end
    end
    if (!b2b) @(negedge clk);
    x16 = m16; src_off = off; dst_addr = dst; byte_cnt = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    do @(negedge clk); while (!done);
    chk(exp_bus_q.size() == 0, tag, "bus items left at done", 32'(exp_bus_q.size()), 32'h0);
    chk(exp_ram_q.size() == 0, tag, "RAM items left at done", 32'(exp_ram_q.size()), 32'h0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 32'(cyc), 32'h0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ce_n, re_n, we_n, cle, ale, ram_we, done} == 7'b1110000, "R1", "outputs in reset",
        32'({ce_n, re_n, we_n, cle, ale, ram_we, done}), 32'h70);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({ce_n, re_n, we_n, cle, ale, ram_we, done} == 7'b1110000, "R1", "idle outputs",
        32'({ce_n, re_n, we_n, cle, ale, ram_we, done}), 32'h70);

    // R6 x16, one page (R9: count 0)
    run_copy(1'b1, 24'h246800, 16'h0100, 24'd0, "R6", 1'b0);
    wait_done("R9");
    repeat (5) @(negedge clk);
    chk(ce_n == 1'b1 && cle == 1'b0 && ale == 1'b0, "R1", "idle after copy",
        32'({ce_n, cle, ale}), 32'h4);

    // R8 x16, two pages with carry into the high row byte
    run_copy(1'b1, 24'hFFFE00, 16'h2000, 24'd512, "R8", 1'b0);
    wait_done("R9");
    repeat (4) @(negedge clk);

    // R7 x8, count 511 -> one page
    run_copy(1'b0, 24'h5A3C00, 16'h4000, 24'd511, "R7", 1'b0);
    wait_done("R9");
    repeat (4) @(negedge clk);

    // R13 x8, two pages, foreign start mid-copy
    run_copy(1'b0, 24'h00FE00, 16'h8000, 24'd512, "R7", 1'b0);
    repeat (300) @(negedge clk);
    x16 = 1'b1; src_off = 24'h111100; dst_addr = 16'hF000; byte_cnt = 24'd4096; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R13");

    // R14 start in the done cycle
    run_copy(1'b1, 24'h000200, 16'hC000, 24'd0, "R14", 1'b1);
    wait_done("R14");
    repeat (5) @(negedge clk);
    chk(done_cnt == 5, "R12", "done pulse count", 32'(done_cnt), 32'd5);
    chk(exp_ram_q.size() == 0 && exp_bus_q.size() == 0, "R13", "no extra copy started",
        32'(exp_ram_q.size() + exp_bus_q.size()), 32'h0);

    summary();
    $finish;
  end
endmodule